// File: doc/BRIEF.md
# Translation Cache with Access Checker

This block is a small fully associative cache of address translations that sits between a processor's memory port and a page table walker. Each access carries a virtual page number, a byte offset, an access kind (read, write or instruction fetch) and the privilege of the requester. On a hit, the block forms the physical address from the cached frame number and the unchanged offset. In that same cycle it checks the cached privilege bit and the cached read, write and execute bits. Any violation gets its own cause code.

On a miss, the block raises a request to the walker and holds it until the walker answers. If the walker reports a fault, that fault goes back to the requester and no entry is written. Otherwise the result fills an entry, and the access, which the requester holds stable, completes as a hit one cycle later. A write that hits an entry whose dirty bit is clear is treated as a miss, so the walker can mark the page dirty in memory. The cache rewrites that same slot.

Entries never follow changes in memory. Software removes stale permissions with a single-page invalidate or a full flush. Either one, if it arrives while a walk is in flight, keeps that walk from filling the cache.

Top module: `xlat_cache`

## Requirements
- R1: When there is no walk in flight, an access that hits a valid entry answers in the same cycle. `resp_paddr` is the cached frame number joined with `req_off`, and `walk_req` does not rise.
- R2: An access that misses raises `walk_req` on the next cycle, with `walk_vpn` equal to the requested page. The request is held until `walk_done`. After a fault-free walk, the entry is filled and the held access completes on the following cycle. The walker's `walk_perm` bits are [4] user-allowed, [3] read, [2] write, [1] execute, [0] dirty.
- R3: A user access (`req_user`=1) to an entry whose user-allowed bit is 0 faults with cause 2 (privilege). This check takes priority over the read, write and execute checks.
- R4: An instruction fetch (`req_kind`=2) from an entry with execute=0 faults with cause 4, and `resp_err[3]` is set.
- R5: A write (`req_kind`=1) to an entry with write=0 faults with cause 3 and `resp_err[1]` set. A read (`req_kind`=0 or 3) to an entry with read=0 faults with cause 6.
- R6: On any fault, `resp_err` is {fetch, user, write, present}. The present bit [0] is 0 only for cause 1 (not present). `resp_cause` is 0 when there is no fault.
- R7: A walker fault is returned with the walker's cause in the `walk_done` cycle: 1 for not present, 5 for reserved bits. Nothing is cached, so a repeat of the access walks again.
- R8: A permitted write that hits an entry whose dirty bit is clear starts a walk. The refill writes the same slot with dirty set, and later writes to that page hit.
- R9: A cached translation stays in use after the page table changes, until `inv_valid` with a matching `inv_vpn` removes it. `flush_all` removes every entry.
- R10: An invalidate of the walked page, or a flush, arriving during a walk or in its `walk_done` cycle prevents the fill. The held access then walks again. An invalidate of another page does not stop the fill.
- R11: Fills after misses take slots in round-robin order over `ENTRIES` (default 8) slots. With the cache full, the next new page evicts the oldest fill. A dirty-refill does not advance the order.
- R12: After reset no entry is valid, `walk_req` and `resp_valid` are low, and the first access to any page walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until `resp_valid` |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Byte offset within the page |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 for a user-mode access |
| resp_valid | output | 1 | Access completes this cycle |
| resp_fault | output | 1 | Access is refused |
| resp_paddr | output | PFN_W+OFF_W | Physical address when not faulting |
| resp_err | output | 4 | {fetch, user, write, present} on a fault |
| resp_cause | output | 3 | 0 none, 1 not present, 2 privilege, 3 write-protect, 4 no-execute, 5 reserved, 6 no-read |
| walk_req | output | 1 | Walk requested, high until `walk_done` |
| walk_vpn | output | VPN_W | Page to walk |
| walk_done | input | 1 | Walker result valid, only while `walk_req` |
| walk_fault | input | 1 | Walker found a fault |
| walk_cause | input | 3 | Walker fault cause (1 or 5) |
| walk_pfn | input | PFN_W | Frame number from the walk |
| walk_perm | input | 5 | {user, read, write, exec, dirty} from the walk |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Page to invalidate |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The fill at the end of a walk can coincide with an invalidate of the same page or with a flush. The bench provokes both. It raises a matching invalidate in the first cycle that `walk_req` is seen, and it raises a flush in the exact cycle it drives `walk_done`. It then judges the outcome by whether the held access triggers a second walk and by the result of that second walk. An invalidate of a neighbouring page during a walk serves as the contrast: that walk must still fill.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam logic [1:0] K_RD = 2'd0;
    localparam logic [1:0] K_WR = 2'd1;
    localparam logic [1:0] K_FX = 2'd2;

    localparam logic [2:0] C_NONE = 3'd0;
    localparam logic [2:0] C_NP   = 3'd1;
    localparam logic [2:0] C_PRIV = 3'd2;
    localparam logic [2:0] C_WP   = 3'd3;
    localparam logic [2:0] C_NX   = 3'd4;
    localparam logic [2:0] C_RSV  = 3'd5;
    localparam logic [2:0] C_NR   = 3'd6;

    typedef struct packed {
        logic u;
        logic r;
        logic w;
        logic x;
        logic d;
    } perm_t;
endpackage

// File: rtl/xc_lookup.sv
module xc_lookup #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0]              vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   tag,
    input  logic [VPN_W-1:0]                key,
    output logic                            hit,
    output logic [IDX_W-1:0]                idx
);
    logic [ENTRIES-1:0] hv;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hv[g] = vld[g] && (tag[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |hv;

    // R11
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hv));
endmodule

// File: rtl/xc_perm.sv
module xc_perm
    import xc_pkg::*;
(
    input  perm_t       perm,
    input  logic [1:0]  kind,
    input  logic        user,
    output logic [2:0]  cause
);
    always_comb begin
        if (user && !perm.u)              cause = C_PRIV;
        else if (kind == K_FX && !perm.x) cause = C_NX;
        else if (kind == K_WR && !perm.w) cause = C_WP;
        else if (kind != K_FX && kind != K_WR && !perm.r) cause = C_NR;
        else                              cause = C_NONE;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [VPN_W-1:0]        req_vpn,
    input  logic [OFF_W-1:0]        req_off,
    input  logic [1:0]              req_kind,
    input  logic                    req_user,
    output logic                    resp_valid,
    output logic                    resp_fault,
    output logic [PFN_W+OFF_W-1:0]  resp_paddr,
    output logic [3:0]              resp_err,
    output logic [2:0]              resp_cause,
    output logic                    walk_req,
    output logic [VPN_W-1:0]        walk_vpn,
    input  logic                    walk_done,
    input  logic                    walk_fault,
    input  logic [2:0]              walk_cause,
    input  logic [PFN_W-1:0]        walk_pfn,
    input  logic [4:0]              walk_perm,
    input  logic                    inv_valid,
    input  logic [VPN_W-1:0]        inv_vpn,
    input  logic                    flush_all
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic                           busy;
        logic                           kill;
        logic                           reuse;
        logic [IDX_W-1:0]               reuse_idx;
        logic [IDX_W-1:0]               ptr;
        logic [VPN_W-1:0]               vpn;
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][VPN_W-1:0]  tag;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        perm_t [ENTRIES-1:0]            perm;
    } st_t;

    st_t st_q, st_d;

    logic             hit;
    logic [IDX_W-1:0] hidx;
    perm_t            hperm;
    logic [2:0]       hcause;

    xc_lookup #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) lookup_i (
        .clk(clk), .rst_n(rst_n), .vld(st_q.vld), .tag(st_q.tag),
        .key(req_vpn), .hit(hit), .idx(hidx)
    );

    assign hperm = st_q.perm[hidx];

    xc_perm perm_i (.perm(hperm), .kind(req_kind), .user(req_user), .cause(hcause));

    logic             is_wr, is_fx, idle_req, hit_ok, w_fault, inv_walk;
    logic [2:0]       cause;
    logic [IDX_W-1:0] slot;
    perm_t            fperm;

    always_comb begin
        st_d     = st_q;
        is_wr    = (req_kind == K_WR);
        is_fx    = (req_kind == K_FX);
        idle_req = req_valid && !st_q.busy;
        inv_walk = inv_valid && (inv_vpn == st_q.vpn);
        hit_ok   = hit && ((hcause != C_NONE) || !(is_wr && !hperm.d));
        w_fault  = st_q.busy && walk_done && walk_fault;
        cause    = w_fault ? walk_cause : hcause;
        slot     = st_q.reuse ? st_q.reuse_idx : st_q.ptr;
        fperm    = perm_t'(walk_perm);
        fperm.d  = fperm.d | is_wr;

        resp_valid = (idle_req && hit_ok) || w_fault;
        resp_fault = resp_valid && (cause != C_NONE);
        resp_cause = resp_fault ? cause : C_NONE;
        resp_err   = resp_fault ? {is_fx, req_user, is_wr, cause != C_NP} : 4'b0;
        resp_paddr = {st_q.pfn[hidx], req_off};

        if (idle_req && !hit_ok) begin
            st_d.busy      = 1'b1;
            st_d.kill      = 1'b0;
            st_d.vpn       = req_vpn;
            st_d.reuse     = hit;
            st_d.reuse_idx = hidx;
        end

        if (flush_all) st_d.vld = '0;
        if (inv_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.tag[i] == inv_vpn) st_d.vld[i] = 1'b0;
            end
        end
        if (st_q.busy && (flush_all || inv_walk)) st_d.kill = 1'b1;

        if (st_q.busy && walk_done) begin
            st_d.busy = 1'b0;
            if (!walk_fault && !st_q.kill && !flush_all && !inv_walk) begin
                st_d.vld[slot]  = 1'b1;
                st_d.tag[slot]  = st_q.vpn;
                st_d.pfn[slot]  = walk_pfn;
                st_d.perm[slot] = fperm;
                if (!st_q.reuse)
                    st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign walk_req = st_q.busy;
    assign walk_vpn = st_q.vpn;

    // R2
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_done |=> walk_req && $stable(walk_vpn));
    // R6
    fault_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> resp_valid && resp_cause != C_NONE);
    // R3
    priv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !walk_req && req_user && !hperm.u |-> resp_cause == C_PRIV);
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> st_q.vld == '0);
    // R10
    kill_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_done && inv_valid && inv_vpn == walk_vpn
        |=> $countones(st_q.vld) <= $countones($past(st_q.vld)));
    // R12
    reset_idle_chk: assert property (@(posedge clk) $fell(rst_n) |=> !walk_req);
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
    localparam int VPN_W = 20, PFN_W = 20, OFF_W = 12, NE = 8, NP = 32;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_user = 0;
    logic [VPN_W-1:0] req_vpn = '0, walk_vpn, inv_vpn = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0] req_kind = 0;
    logic resp_valid, resp_fault, walk_req;
    logic [PFN_W+OFF_W-1:0] resp_paddr;
    logic [3:0] resp_err;
    logic [2:0] resp_cause, walk_cause = 0;
    logic walk_done = 0, walk_fault = 0, inv_valid = 0, flush_all = 0;
    logic [PFN_W-1:0] walk_pfn = '0;
    logic [4:0] walk_perm = '0;

    always #5 clk = ~clk;

    xlat_cache #(.ENTRIES(NE), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) dut_i (.*);

    int total = 0, bad = 0;
    // page table held by the bench
    logic [PFN_W-1:0] pt_pfn [NP];
    logic [4:0]       pt_perm[NP];
    logic [2:0]       pt_fc  [NP];
    // expected cache contents
    logic             sh_v   [NE];
    logic [VPN_W-1:0] sh_vpn [NE];
    logic [PFN_W-1:0] sh_pfn [NE];
    logic [4:0]       sh_perm[NE];
    int               sh_ptr = 0;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [2:0] pchk(input logic [4:0] p, input logic [1:0] k, input logic u);
        if (u && !p[4]) return 3'd2;
        if (k == 2 && !p[1]) return 3'd4;
        if (k == 1 && !p[2]) return 3'd3;
        if (k != 1 && k != 2 && !p[3]) return 3'd6;
        return 3'd0;
    endfunction

    function automatic int sh_find(input int vpn);
        for (int i = 0; i < NE; i++) if (sh_v[i] && sh_vpn[i] == VPN_W'(vpn)) return i;
        return -1;
    endfunction

    task automatic sh_inv(input int vpn);
        for (int i = 0; i < NE; i++) if (sh_vpn[i] == VPN_W'(vpn)) sh_v[i] = 0;
    endtask

    task automatic sh_flush();
        for (int i = 0; i < NE; i++) sh_v[i] = 0;
    endtask

    task automatic setpg(input int vpn, input logic [4:0] p, input logic [2:0] fc);
        pt_perm[vpn] = p;
        pt_fc[vpn] = fc;
        pt_pfn[vpn] = PFN_W'($urandom);
    endtask

    // mode: 0 plain, 1 invalidate same page in walk, 2 flush at walk_done, 3 invalidate other page
    task automatic access(input int vpn, input logic [1:0] kind, input logic user,
                          input int mode, input string rq);
        int h, ewalks, nwalk, wcnt, dly, guard, slot;
        logic [2:0] ecause;
        logic [PFN_W-1:0] epfn;
        logic [4:0] fp;
        logic [OFF_W-1:0] off;
        logic got, gfault;
        logic [2:0] gcause;
        logic [3:0] gerr, eerr;
        logic [PFN_W+OFF_W-1:0] gpa;
        bit bad_vpn;
        off = OFF_W'($urandom);
        // prediction
        if (mode == 1) sh_inv(vpn);
        if (mode == 3) sh_inv(vpn ^ 1);
        if (mode == 2) sh_flush();
        h = sh_find(vpn);
        ewalks = 0; ecause = 0; epfn = '0;
        if (h >= 0 && (pchk(sh_perm[h], kind, user) != 0 || !(kind == 1 && !sh_perm[h][0]))) begin
            ecause = pchk(sh_perm[h], kind, user);
            epfn = sh_pfn[h];
        end else begin
            ewalks = (mode == 1 || mode == 2) ? 2 : 1;
            if (pt_fc[vpn] != 0) begin
                ecause = pt_fc[vpn];
                ewalks = 1;
            end else begin
                fp = pt_perm[vpn] | {4'b0, kind == 1};
                slot = (h >= 0) ? h : sh_ptr;
                if (h < 0) sh_ptr = (sh_ptr + 1) % NE;
                sh_v[slot] = 1; sh_vpn[slot] = VPN_W'(vpn);
                sh_pfn[slot] = pt_pfn[vpn]; sh_perm[slot] = fp;
                ecause = pchk(fp, kind, user);
                epfn = pt_pfn[vpn];
            end
        end
        eerr = (ecause != 0) ? {kind == 2, user, kind == 1, ecause != 1} : 4'b0;
        // drive
        @(negedge clk);
        req_valid = 1; req_vpn = VPN_W'(vpn); req_off = off; req_kind = kind; req_user = user;
        nwalk = 0; wcnt = 0; dly = 1 + int'($urandom % 3); got = 0; guard = 0; bad_vpn = 0;
        gfault = 0; gcause = 0; gerr = 0; gpa = '0;
        while (!got && guard < 60) begin
            walk_done = 0; inv_valid = 0; flush_all = 0;
            if (walk_req) begin
                if (walk_vpn != VPN_W'(vpn)) bad_vpn = 1;
                if (wcnt == 0 && nwalk == 0 && (mode == 1 || mode == 3)) begin
                    inv_valid = 1;
                    inv_vpn = (mode == 1) ? VPN_W'(vpn) : VPN_W'(vpn ^ 1);
                end
                if (wcnt == dly) begin
                    walk_done = 1;
                    walk_fault = (pt_fc[vpn] != 0);
                    walk_cause = pt_fc[vpn];
                    walk_pfn = pt_pfn[vpn];
                    walk_perm = pt_perm[vpn] | {4'b0, kind == 1};
                    if (pt_fc[vpn] == 0 && kind == 1) pt_perm[vpn][0] = 1'b1;
                    if (nwalk == 0 && mode == 2) flush_all = 1;
                    nwalk++;
                    wcnt = 0;
                end else wcnt++;
            end
            #1;
            if (resp_valid) begin
                got = 1; gfault = resp_fault; gcause = resp_cause; gerr = resp_err; gpa = resp_paddr;
            end
            @(negedge clk);
            guard++;
        end
        req_valid = 0; walk_done = 0; inv_valid = 0; flush_all = 0;
        check(got, {rq, " completes"}, got, 1);
        check(!bad_vpn, {rq, " walk page"}, bad_vpn, 0);
        check(nwalk == ewalks, {rq, " walk count"}, nwalk, ewalks);
        check(gcause == ecause && gfault == (ecause != 0), {rq, " cause"}, gcause, ecause);
        check(gerr == eerr, {rq, " error code R6"}, gerr, eerr);
        if (ecause == 0) check(gpa == {epfn, off}, {rq, " address"}, gpa, {epfn, off});
    endtask

    task automatic inv_page(input int vpn);
        @(negedge clk);
        inv_valid = 1; inv_vpn = VPN_W'(vpn);
        @(negedge clk);
        inv_valid = 0;
        sh_inv(vpn);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_all = 1;
        @(negedge clk);
        flush_all = 0;
        sh_flush();
    endtask

    initial begin
        int seed;
        seed = int'($urandom(32'd4242));
        for (int i = 0; i < NE; i++) begin sh_v[i] = 0; sh_vpn[i] = '0; sh_pfn[i] = '0; sh_perm[i] = '0; end
        for (int i = 0; i < NP; i++)
            setpg(i, 5'($urandom), ($urandom % 8 == 0) ? (($urandom % 2) ? 3'd1 : 3'd5) : 3'd0);
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        check(!walk_req && !resp_valid, "R12 idle after reset", {walk_req, resp_valid}, 0);
        rst_n = 1;
        setpg(20, 5'b11111, 0);
        access(20, 0, 1, 0, "R12 first access walks / R2 fill");
        access(20, 0, 1, 0, "R1 hit");
        // R9 stale entry then invalidate
        access(20, 1, 1, 0, "R9 setup write");
        pt_perm[20][2] = 1'b0;
        access(20, 1, 1, 0, "R9 stale write still allowed");
        inv_page(20);
        access(20, 1, 1, 0, "R9 after invalidate R5");
        // R3 privilege over write-protect
        setpg(21, 5'b01001, 0);
        access(21, 1, 1, 0, "R3 privilege first");
        access(21, 0, 0, 0, "R3 supervisor read ok");
        // R4 no-execute
        setpg(22, 5'b11101, 0);
        access(22, 2, 1, 0, "R4 fetch no-exec");
        // R5 no-read
        setpg(19, 5'b10111, 0);
        access(19, 0, 0, 0, "R5 read denied");
        // R7 walker faults
        setpg(23, 5'b11111, 1);
        access(23, 0, 1, 0, "R7 not present");
        access(23, 0, 1, 0, "R7 repeat walks");
        setpg(18, 5'b11111, 5);
        access(18, 2, 0, 0, "R7 reserved");
        // R8 dirty refill
        setpg(24, 5'b11110, 0);
        access(24, 0, 1, 0, "R8 read fill clean");
        access(24, 1, 1, 0, "R8 write on clean walks");
        access(24, 1, 1, 0, "R8 write hits");
        // R10 collisions with an in-flight walk
        setpg(25, 5'b11111, 0); setpg(26, 5'b11111, 0); setpg(27, 5'b11111, 0);
        access(25, 0, 1, 1, "R10 invalidate during walk");
        access(26, 0, 1, 2, "R10 flush at walk_done");
        access(27, 0, 1, 3, "R10 other-page invalidate fills");
        access(27, 0, 1, 0, "R10 filled entry hits");
        // R11 round robin eviction
        do_flush();
        for (int v = 0; v < 9; v++) setpg(v, 5'b11111, 0);
        for (int v = 0; v < 9; v++) access(v, 0, 1, 0, "R11 fill");
        access(0, 0, 1, 0, "R11 oldest evicted");
        access(3, 0, 1, 0, "R11 newer kept");
        // R9 flush empties
        do_flush();
        access(5, 0, 1, 0, "R9 flush forces walk");
        // random phase
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 40 == 0) do_flush();
            else if ($urandom % 25 == 0) inv_page(int'($urandom % 16));
            access(int'($urandom % 16), 2'($urandom % 4), 1'($urandom), 0, "R1 R2 R5 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule